// File: doc/BRIEF.md
# Serial CRC Encoder and Checker

This block computes a cyclic redundancy remainder one bit per clock with a shift register as wide as the degree of the generator polynomial. A feedback XOR sits only at the bit positions whose polynomial coefficient is one, because in modulo-two arithmetic both addition and subtraction are XOR and long division comes down to shifting and XOR. The generator defaults to x^3+x^2+1 (binary 1101), so the remainder is 3 bits wide.

In encode mode the block takes a message with its most significant bit first and passes each bit straight to the serial output. After the last bit it feeds degree-many zero bits into the divider without producing output, which is the augmentation step. It then shifts the remainder out, most significant bit first. The frame leaving the block is the message with the remainder in the augmentation positions, so no payload bit is disturbed. In check mode the block takes a whole frame and outputs the payload through a delay line of degree-many bits, so the trailing check bits never reach the output. After the last bit it raises `crc_ok` only when the remainder is zero.

The controller has four states. IDLE waits for a valid bit marked start. That transition either goes to SHIFT, or, for a one-bit frame, goes to AUG (encode) or stays in IDLE with the done pulse (check). SHIFT takes bits until one is marked last. From there it goes to AUG in encode mode or back to IDLE in check mode. AUG feeds degree-many zeros and moves to EMIT. EMIT shifts out the remainder and returns to IDLE with the done pulse.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset `out_valid`, `out_done` and `crc_ok` are low and the block waits in IDLE.
- R2: In encode mode every accepted message bit appears on `out_bit` with `out_valid` high, unchanged and in arrival order, one cycle after it is accepted.
- R3: In encode mode, after the bit marked last, there are degree-many cycles with no output. Then the remainder of (message times x^degree) divided by the generator follows, most significant bit first, and `out_done` is high with its final bit. Message 0xD6B5 gives remainder 101 and frame 0x6B5AD.
- R4: Bits presented with `in_valid` high while the remainder is being computed or emitted, and bits with `in_valid` high but `in_start` low while in IDLE, have no effect on the output stream.
- R5: In check mode a frame of N bits produces exactly its first N minus degree bits on the output, in order. The final degree-many bits are never output, and frames of degree bits or fewer produce no output.
- R6: In check mode `out_done` pulses one cycle after the last bit is accepted, together with the final payload bit when there is one. `crc_ok` is high in that cycle only when the remainder of the whole frame is zero, and `crc_ok` is never high without `out_done`.
- R7: A frame produced by the encoder passes the check, and the same frame with any one bit inverted fails it.
- R8: A start bit clears the remainder and the payload delay line, so a frame's result does not depend on the frame before it.
- R9: Cycles with `in_valid` low inside a frame change nothing. The result equals that of the same bits sent without gaps.
- R10: `chk_mode` is sampled with the start bit: 0 selects encode and 1 selects check, for the whole frame.
- R11: In encode mode `crc_ok` stays low, including on the `out_done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_mode | input | 1 | Mode sampled with the start bit: 0 encode, 1 check |
| in_valid | input | 1 | Serial input bit is present this cycle |
| in_start | input | 1 | Marks the first bit of a frame |
| in_last | input | 1 | Marks the final bit of a frame |
| in_bit | input | 1 | Serial data in, most significant bit first |
| out_valid | output | 1 | Serial output bit is present this cycle |
| out_bit | output | 1 | Serial data out |
| out_done | output | 1 | One-cycle pulse at the end of a frame |
| crc_ok | output | 1 | Check-mode result, high with `out_done` when the remainder is zero |

## Verification
The bench builds the block with its default generator, x^3+x^2+1 of degree 3. Because the remainder has only eight values, random messages of 1 to 40 bits land on every remainder, including zero, many times over. Frames shorter than, equal to and just above the degree are cheap to reach, and they cover the empty-payload cases of the checker. The small degree also keeps the augmentation and emission windows short, so random gaps and stray input bits fall into them often. Every single-bit corruption of the directed 19-bit frame is tried.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_AUG,
        ST_EMIT
    } crc_state_e;

    typedef enum logic [2:0] {
        REM_HOLD,
        REM_LOAD,
        REM_DIV,
        REM_ZFEED,
        REM_EMIT
    } rem_op_e;

endpackage

// File: rtl/crc_rem_reg.sv
module crc_rem_reg
    import crc_pkg::*;
#(
    parameter int          DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic           clk,
    input  logic           rst_n,
    input  rem_op_e        op,
    input  logic           din,
    output logic [DEG-1:0] rem_q,
    output logic           div_zero
);
    localparam logic [DEG-1:0] TAPS = POLY[DEG-1:0];

    logic [DEG-1:0] shifted;
    logic [DEG-1:0] div_din;
    logic [DEG-1:0] rem_d;
    logic           msb;

    assign msb = rem_q[DEG-1];

    // One divider step: shift in din, XOR the generator where its coefficient is one.
    for (genvar i = 0; i < DEG; i++) begin : g_stage
        if (i == 0) begin : g_in
            assign shifted[i] = din;
        end else begin : g_sh
            assign shifted[i] = rem_q[i-1];
        end
        if (TAPS[i]) begin : g_tap
            assign div_din[i] = shifted[i] ^ msb;
        end else begin : g_wire
            assign div_din[i] = shifted[i];
        end
    end

    assign div_zero = (div_din == '0);

    always_comb begin
        unique case (op)
            REM_LOAD:  rem_d = {{(DEG-1){1'b0}}, din};
            REM_DIV:   rem_d = div_din;
            REM_ZFEED: rem_d = div_din ^ {{(DEG-1){1'b0}}, din};
            REM_EMIT:  rem_d = rem_q << 1;
            default:   rem_d = rem_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end
endmodule

// File: rtl/crc_tap_delay.sv
module crc_tap_delay #(
    parameter int DEG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic push,
    input  logic din,
    output logic dout,
    output logic full
);
    localparam int SW = $clog2(DEG + 1);
    localparam logic [SW-1:0] FILL = SW'(DEG);

    logic [DEG-1:0] line_q;
    logic [SW-1:0]  seen_q;

    assign dout = line_q[DEG-1];
    assign full = (seen_q == FILL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            seen_q <= '0;
        end else if (load) begin
            line_q <= {{(DEG-1){1'b0}}, din};
            seen_q <= SW'(1);
        end else if (push) begin
            line_q <= (line_q << 1) | {{(DEG-1){1'b0}}, din};
            if (!full) seen_q <= seen_q + SW'(1);
        end
    end
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
    import crc_pkg::*;
#(
    parameter int           DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_mode,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_last,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit,
    output logic out_done,
    output logic crc_ok
);
    localparam int CW = (DEG > 1) ? $clog2(DEG) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(DEG - 1);

    crc_state_e     state_q, state_d;
    logic           mode_q, mode_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    rem_op_e        rem_op;
    logic [DEG-1:0] rem_q;
    logic           div_zero;
    logic           dl_load, dl_push, dl_out, dl_full;
    logic           ov_d, ob_d, od_d, ok_d;

    crc_rem_reg #(.DEG(DEG), .POLY(POLY)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (rem_op),
        .din      (in_bit),
        .rem_q    (rem_q),
        .div_zero (div_zero)
    );

    crc_tap_delay #(.DEG(DEG)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dl_load),
        .push  (dl_push),
        .din   (in_bit),
        .dout  (dl_out),
        .full  (dl_full)
    );

    // Next-state and next-output logic.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cnt_d   = cnt_q;
        rem_op  = REM_HOLD;
        dl_load = 1'b0;
        dl_push = 1'b0;
        ov_d    = 1'b0;
        ob_d    = 1'b0;
        od_d    = 1'b0;
        ok_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_start) begin
                    mode_d  = chk_mode;
                    rem_op  = REM_LOAD;
                    dl_load = 1'b1;
                    if (!chk_mode) begin
                        ov_d = 1'b1;
                        ob_d = in_bit;
                    end
                    if (!in_last) begin
                        state_d = ST_SHIFT;
                    end else if (!chk_mode) begin
                        state_d = ST_AUG;
                        cnt_d   = '0;
                    end else begin
                        od_d = 1'b1;
                        ok_d = !in_bit;
                    end
                end
            end
            ST_SHIFT: begin
                if (in_valid) begin
                    rem_op  = REM_DIV;
                    dl_push = 1'b1;
                    if (!mode_q) begin
                        ov_d = 1'b1;
                        ob_d = in_bit;
                    end else if (dl_full) begin
                        ov_d = 1'b1;
                        ob_d = dl_out;
                    end
                    if (in_last) begin
                        if (!mode_q) begin
                            state_d = ST_AUG;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_IDLE;
                            od_d    = 1'b1;
                            ok_d    = div_zero;
                        end
                    end
                end
            end
            ST_AUG: begin
                rem_op = REM_ZFEED;
                if (cnt_q == LAST_CNT) begin
                    state_d = ST_EMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_EMIT: begin
                rem_op = REM_EMIT;
                ov_d   = 1'b1;
                ob_d   = rem_q[DEG-1];
                if (cnt_q == LAST_CNT) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    od_d    = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_done  <= 1'b0;
            crc_ok    <= 1'b0;
        end else begin
            out_valid <= ov_d;
            out_bit   <= ob_d;
            out_done  <= od_d;
            crc_ok    <= ok_d;
        end
    end
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk
    import crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  crc_state_e state_q,
    input  logic       mode_q,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       out_valid,
    input  logic       out_done,
    input  logic       crc_ok
);
    p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> out_done);

    p_aug_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AUG) |=> !out_valid);

    p_emit_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |=> out_valid);

    p_check_skips_aug_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AUG || state_q == ST_EMIT) |-> !mode_q);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(in_valid && in_start)) |=> (!out_valid && !out_done));

    p_encode_no_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !mode_q) |-> !crc_ok);
endmodule

bind crc_serial_unit crc_serial_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .mode_q    (mode_q),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .out_valid (out_valid),
    .out_done  (out_done),
    .crc_ok    (crc_ok)
);

// File: tb/crc_serial_unit_tb_top.sv
module crc_serial_unit_tb_top;
    localparam int           DEG  = 3;
    localparam logic [DEG:0] POLY = 4'b1101;
    localparam logic [DEG-1:0] TAPS = POLY[DEG-1:0];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_mode = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic in_last = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid, out_bit, out_done, crc_ok;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] cap;
    int          ccount;
    int          dcount;
    logic        okv;
    logic        dwv;

    always #10 clk = ~clk;

    crc_serial_unit #(.DEG(DEG), .POLY(POLY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_mode  (chk_mode),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_last   (in_last),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_done  (out_done),
        .crc_ok    (crc_ok)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            cap    = {cap[62:0], out_bit};
            ccount = ccount + 1;
        end
        if (out_done) begin
            dcount = dcount + 1;
            okv    = crc_ok;
            if (!out_valid) dwv = 1'b0;
        end
    end

    function automatic logic [DEG-1:0] ref_rem(input logic [63:0] v, input int n);
        logic [DEG-1:0] r = '0;
        logic           fb;
        for (int i = n - 1; i >= 0; i--) begin
            fb = r[DEG-1];
            r  = {r[DEG-2:0], v[i]} ^ (fb ? TAPS : '0);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic mode, input logic [63:0] v, input int n,
                        input int gap_pct, input bit junk);
        cap = '0; ccount = 0; dcount = 0; okv = 1'b0; dwv = 1'b1;
        chk_mode = mode;
        for (int i = n - 1; i >= 0; i--) begin
            if (i != n - 1 && int'($urandom % 100) < gap_pct) begin
                in_valid = 1'b0; in_start = 1'($urandom); in_last = 1'($urandom);
                in_bit = 1'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1; in_start = (i == n - 1); in_last = (i == 0); in_bit = v[i];
            @(negedge clk);
            chk_mode = 1'($urandom);
        end
        in_start = 1'b0;
        if (junk) begin
            for (int k = 0; k < 2 * DEG + 2; k++) begin
                in_valid = 1'b1; in_last = 1'($urandom); in_bit = 1'($urandom);
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (2 * DEG + 3) @(negedge clk);
    endtask

    task automatic do_encode(input logic [63:0] v, input int n, input int gap_pct,
                             input bit junk, output logic [63:0] frame);
        logic [63:0] aug = v << DEG;
        frame = aug | 64'(ref_rem(aug, n + DEG));
        send(1'b0, v, n, gap_pct, junk);
        chk("R2 R3 encode stream", cap, frame);
        chk("R2 R3 encode bit count", 64'(ccount), 64'(n + DEG));
        chk("R3 encode done pulses", 64'(dcount), 64'd1);
        chk("R11 encode crc_ok low", 64'(okv), 64'd0);
    endtask

    task automatic do_check(input logic [63:0] f, input int n, input int gap_pct,
                            input string tag);
        int pl = (n > DEG) ? n - DEG : 0;
        send(1'b1, f, n, gap_pct, 1'b0);
        chk({tag, " R5 payload"}, cap, (n > DEG) ? (f >> DEG) : 64'd0);
        chk({tag, " R5 payload count"}, 64'(ccount), 64'(pl));
        chk({tag, " R6 done pulses"}, 64'(dcount), 64'd1);
        chk({tag, " R6 crc_ok"}, 64'(okv), 64'(ref_rem(f, n) == '0));
        if (n > DEG) chk({tag, " R6 done with last payload"}, 64'(dwv), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] fr;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid at reset", 64'(out_valid), 64'd0);
        chk("R1 out_done at reset", 64'(out_done), 64'd0);
        chk("R1 crc_ok at reset", 64'(crc_ok), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 directed: 0xD6B5 gives remainder 101, frame 0x6B5AD
        do_encode(64'hD6B5, 16, 0, 1'b0, fr);
        chk("R3 remainder 101", 64'(cap[2:0]), 64'b101);
        chk("R3 frame 0x6B5AD", cap, 64'h6B5AD);

        // R5 R6 directed check of the good frame
        do_check(64'h6B5AD, 19, 0, "R7 good");
        chk("R7 good frame passes", 64'(okv), 64'd1);

        // R7: every single-bit flip fails; R8: following good frame passes
        for (int i = 0; i < 19; i++) begin
            do_check(64'h6B5AD ^ (64'd1 << i), 19, 0, "R7 flip");
            chk("R7 flipped frame fails", 64'(okv), 64'd0);
        end
        do_check(64'h6B5AD, 19, 0, "R8 after bad");
        chk("R8 clean after failing frame", 64'(okv), 64'd1);

        // R4: stray bits during augmentation and emission
        do_encode(64'hD6B5, 16, 0, 1'b1, fr);
        chk("R4 junk ignored", cap, 64'h6B5AD);

        // R9: gaps inside frames
        do_encode(64'hD6B5, 16, 50, 1'b0, fr);
        chk("R9 gaps encode", cap, 64'h6B5AD);
        do_check(64'h6B5AD, 19, 50, "R9 gaps");

        // Short frames at the degree boundary (R5)
        do_check(64'b1, 1, 0, "R5 len1 one");
        do_check(64'b0, 1, 0, "R5 len1 zero");
        do_check(64'b000, 3, 0, "R5 len3");
        do_check(64'b1101, 4, 0, "R5 len4");
        do_encode(64'b1, 1, 0, 1'b0, fr);

        // Random mix (R10 mode alternates per frame)
        for (int it = 0; it < 30; it++) begin
            int n = 1 + int'($urandom % 40);
            logic [63:0] m = {$urandom, $urandom} & ((64'd1 << n) - 1);
            do_encode(m, n, 20, 1'(it & 1), fr);
            if ($urandom % 2) begin
                fr = fr ^ (64'd1 << ($urandom % (n + DEG)));
                do_check(fr, n + DEG, 20, "R10 R7 corrupted");
                chk("R7 random flip fails", 64'(okv), 64'd0);
            end else begin
                do_check(fr, n + DEG, 20, "R10 R7 clean");
                chk("R7 encoder frame passes", 64'(okv), 64'd1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule